// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short ordered record of how finished transmissions ended. When the transmit engine reports a finished frame that either failed (jabber, underrun, too many collisions) or asked for an interrupt on success, one status byte is stored. Frames that succeed without asking for an interrupt leave no record.

The host sees the oldest stored record on an 8-bit read port. Any host write to that port discards the record, and the next oldest appears. A transmit-complete event stays asserted while any record is waiting. If a record arrives when the store is full, it is dropped and a lost-record flag is set in the record the host will read next.

The block also tracks two conditions that stop the transmitter. A jabber or underrun completion halts the transmitter. A transmit FIFO overrun halts it and raises an adapter-failure indication. Both last until a transmit reset or a global reset.

Top module: `tx_done_stack`

## Requirements
- R1: A record is stored only when `done_valid` is high and at least one of `done_int_req`, `done_jabber`, `done_underrun` or `done_max_coll` is high. A completion with none of them set stores nothing.
- R2: A nonempty read port shows bit 7 = 1 (complete), bit 6 = interrupt request, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = lost-record flag, and bits 1..0 = 0.
- R3: Records are read out oldest first.
- R4: A `host_wr` pulse discards the record on the read port. When the store is empty, the port reads 0x00 and a write changes nothing.
- R5: A record that arrives while all DEPTH (default 4) slots are full is dropped, and bit 2 is set in the record currently on the read port.
- R6: A record that arrives in the same cycle as a pop is accepted even when the store is full, and no lost-record flag is set.
- R7: `tx_complete_evt` is high exactly while at least one record is stored.
- R8: A completion with jabber or underrun sets `tx_halted`, which stays set until `tx_reset` or `rst`. `tx_reset` leaves the stored records in place.
- R9: `fifo_overrun` sets both `tx_halted` and `adapter_fail`, and both stay set until `tx_reset` or `rst`.
- R10: `rst` empties the store and clears `tx_halted` and `adapter_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| done_valid | input | 1 | Transmit engine reports a finished frame |
| done_int_req | input | 1 | Frame asked for an interrupt on success |
| done_jabber | input | 1 | Frame ended with a jabber error |
| done_underrun | input | 1 | Frame ended with an underrun |
| done_max_coll | input | 1 | Frame hit the collision limit |
| fifo_overrun | input | 1 | Transmit FIFO overrun pulse |
| tx_reset | input | 1 | Transmit reset command |
| host_wr | input | 1 | Host write to the status port (pops the record) |
| host_rd_data | output | 8 | Oldest record, or 0x00 when empty |
| tx_complete_evt | output | 1 | Records are waiting |
| tx_halted | output | 1 | Transmitter stopped by an error |
| adapter_fail | output | 1 | FIFO overrun failure indication |

## Verification
On every cycle, the assertions check the following:
- the occupancy bound;
- that an empty store reads zero;
- that a pop shrinks the store by one;
- that an overfull push shows the lost-record flag;
- that the event drops once the last record leaves;
- that the halt and failure flags set and hold.

Only the directed scenarios can show oldest-first ordering across several records, the exact byte values of each error combination, the accepted push during a pop at full depth, and the fact that a transmit reset keeps the records.

// File: rtl/txs_pkg.sv
package txs_pkg;
  // Flag payload of one completion record, most significant first
  typedef struct packed {
    logic int_req;
    logic jabber;
    logic underrun;
    logic max_coll;
  } txs_rec_t;
endpackage

// File: rtl/txs_entry_fmt.sv
module txs_entry_fmt
  import txs_pkg::*;
(
  input  logic     done_valid,
  input  logic     done_int_req,
  input  logic     done_jabber,
  input  logic     done_underrun,
  input  logic     done_max_coll,
  output logic     push,
  output txs_rec_t rec,
  output logic     err_evt
);
  always_comb begin
    rec.int_req  = done_int_req;
    rec.jabber   = done_jabber;
    rec.underrun = done_underrun;
    rec.max_coll = done_max_coll;
    // R1: only failures or interrupt requests leave a record
    push    = done_valid && (done_int_req || done_jabber || done_underrun || done_max_coll);
    err_evt = done_valid && (done_jabber || done_underrun);
  end
endmodule

// File: rtl/txs_store.sv
module txs_store
  import txs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  txs_rec_t   rec,
  input  logic       pop,
  output logic [7:0] head_byte,
  output logic       nonempty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  txs_rec_t          mem [DEPTH];
  logic [DEPTH-1:0]  ovf;
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              do_pop, do_push, drop;

  always_comb begin
    do_pop  = pop && (count != '0);
    do_push = push && ((count != FULL) || do_pop);
    drop    = push && !do_push;
  end

  // payload storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= rec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= '0;
    end else begin
      if (do_push) begin
        wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        ovf[wr_ptr] <= 1'b0;
      end
      if (drop) ovf[rd_ptr] <= 1'b1;
      if (do_pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    nonempty = (count != '0);
    if (nonempty) head_byte = {1'b1, mem[rd_ptr], ovf[rd_ptr], 2'b00};
    else          head_byte = 8'h00;
  end

  p_bound_r5: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);
  p_empty_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> (head_byte == 8'h00));
  p_pop_shrinks_r4: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && count != '0) |=> (count == $past(count) - 1'b1));
  p_drop_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (count == FULL && push && !pop) |=> head_byte[2]);
  p_evt_falls_r7: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(1) && pop && !push) |=> !nonempty);
endmodule

// File: rtl/txs_halt_ctl.sv
module txs_halt_ctl (
  input  logic clk,
  input  logic rst,
  input  logic err_evt,
  input  logic fifo_overrun,
  input  logic tx_reset,
  output logic tx_halted,
  output logic adapter_fail
);
  always_ff @(posedge clk) begin
    if (rst || tx_reset) begin
      tx_halted    <= 1'b0;
      adapter_fail <= 1'b0;
    end else begin
      if (err_evt || fifo_overrun) tx_halted <= 1'b1;
      if (fifo_overrun) adapter_fail <= 1'b1;
    end
  end

  p_err_halts_r8: assert property (@(posedge clk) disable iff (rst)
    (err_evt && !tx_reset) |=> tx_halted);
  p_ovr_fails_r9: assert property (@(posedge clk) disable iff (rst)
    (fifo_overrun && !tx_reset) |=> (tx_halted && adapter_fail));
  p_fail_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (adapter_fail && !tx_reset) |=> adapter_fail);
  p_halt_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_halted && !tx_reset) |=> tx_halted);
endmodule

// File: rtl/tx_done_stack.sv
module tx_done_stack
  import txs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       done_valid,
  input  logic       done_int_req,
  input  logic       done_jabber,
  input  logic       done_underrun,
  input  logic       done_max_coll,
  input  logic       fifo_overrun,
  input  logic       tx_reset,
  input  logic       host_wr,
  output logic [7:0] host_rd_data,
  output logic       tx_complete_evt,
  output logic       tx_halted,
  output logic       adapter_fail
);
  logic     push, err_evt;
  txs_rec_t rec;

  txs_entry_fmt u_fmt (
    .done_valid    (done_valid),
    .done_int_req  (done_int_req),
    .done_jabber   (done_jabber),
    .done_underrun (done_underrun),
    .done_max_coll (done_max_coll),
    .push          (push),
    .rec           (rec),
    .err_evt       (err_evt)
  );

  txs_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .rec       (rec),
    .pop       (host_wr),
    .head_byte (host_rd_data),
    .nonempty  (tx_complete_evt)
  );

  txs_halt_ctl u_halt (
    .clk          (clk),
    .rst          (rst),
    .err_evt      (err_evt),
    .fifo_overrun (fifo_overrun),
    .tx_reset     (tx_reset),
    .tx_halted    (tx_halted),
    .adapter_fail (adapter_fail)
  );
endmodule

// File: tb/tx_done_stack_test.sv
module tx_done_stack_test;
  logic clk = 1'b0;
  logic rst, done_valid, done_int_req, done_jabber, done_underrun, done_max_coll;
  logic fifo_overrun, tx_reset, host_wr;
  logic [7:0] host_rd_data;
  logic tx_complete_evt, tx_halted, adapter_fail;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tx_done_stack #(.DEPTH(4)) uut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    done_valid = 0; done_int_req = 0; done_jabber = 0; done_underrun = 0;
    done_max_coll = 0; fifo_overrun = 0; tx_reset = 0; host_wr = 0;
  endtask

  // Drive for one clock; flags = {int_req, jabber, underrun, max_coll}
  task automatic cyc(logic v, logic [3:0] f, logic wr);
    done_valid = v;
    {done_int_req, done_jabber, done_underrun, done_max_coll} = f;
    host_wr = wr;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    rst = 1; idle();
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 port", host_rd_data, 8'h00);
    chk("R10 evt", {7'd0, tx_complete_evt}, 8'd0);
    chk("R10 halt", {6'd0, tx_halted, adapter_fail}, 8'd0);
  endtask

  task automatic t_qualify();
    cyc(1, 4'b0000, 0);
    chk("R1 plain success ignored", host_rd_data, 8'h00);
    chk("R1 evt stays low", {7'd0, tx_complete_evt}, 8'd0);
    cyc(1, 4'b0001, 0);
    chk("R1 R2 max coll byte", host_rd_data, 8'h88);
    chk("R7 evt high", {7'd0, tx_complete_evt}, 8'd1);
    cyc(0, 4'b1111, 0);
    chk("R1 no valid no push", host_rd_data, 8'h88);
    cyc(0, 0, 1);
    chk("R4 pop to empty", host_rd_data, 8'h00);
    chk("R7 evt low", {7'd0, tx_complete_evt}, 8'd0);
  endtask

  task automatic t_order();
    cyc(1, 4'b1000, 0);
    cyc(1, 4'b0001, 0);
    cyc(1, 4'b1001, 0);
    chk("R3 first", host_rd_data, 8'hC0);
    cyc(0, 0, 1);
    chk("R3 second", host_rd_data, 8'h88);
    cyc(0, 0, 1);
    chk("R3 R2 third", host_rd_data, 8'hC8);
    cyc(0, 0, 1);
    chk("R4 empty after", host_rd_data, 8'h00);
  endtask

  task automatic t_overflow();
    cyc(1, 4'b1000, 0); cyc(1, 4'b0001, 0);
    cyc(1, 4'b1000, 0); cyc(1, 4'b0001, 0);
    chk("R5 full head", host_rd_data, 8'hC0);
    cyc(1, 4'b1001, 0);
    chk("R5 lost flag on head", host_rd_data, 8'hC4);
    cyc(0, 0, 1); chk("R5 next", host_rd_data, 8'h88);
    cyc(0, 0, 1); chk("R5 next", host_rd_data, 8'hC0);
    cyc(0, 0, 1); chk("R5 last kept", host_rd_data, 8'h88);
    cyc(0, 0, 1); chk("R5 dropped record absent", host_rd_data, 8'h00);
  endtask

  task automatic t_simul();
    cyc(1, 4'b1000, 0); cyc(1, 4'b0001, 0);
    cyc(1, 4'b1000, 0); cyc(1, 4'b0001, 0);
    cyc(1, 4'b1001, 1);
    chk("R6 head after pop no flag", host_rd_data, 8'h88);
    cyc(0, 0, 1); chk("R6 order", host_rd_data, 8'hC0);
    cyc(0, 0, 1); chk("R6 order", host_rd_data, 8'h88);
    cyc(0, 0, 1); chk("R6 accepted record", host_rd_data, 8'hC8);
    cyc(0, 0, 1); chk("R6 empty", {7'd0, tx_complete_evt}, 8'd0);
  endtask

  task automatic t_empty_pop();
    cyc(0, 0, 1);
    chk("R4 write on empty", host_rd_data, 8'h00);
    cyc(1, 4'b1000, 1);
    chk("R4 push with empty pop", host_rd_data, 8'hC0);
    cyc(0, 0, 1);
    chk("R4 single record popped", host_rd_data, 8'h00);
    cyc(0, 0, 1);
    chk("R7 evt still low", {7'd0, tx_complete_evt}, 8'd0);
  endtask

  task automatic t_halt();
    cyc(1, 4'b0100, 0);
    chk("R8 R2 jabber byte", host_rd_data, 8'hA0);
    chk("R8 halted", {7'd0, tx_halted}, 8'd1);
    repeat (3) @(negedge clk);
    chk("R8 halt holds", {7'd0, tx_halted}, 8'd1);
    tx_reset = 1; @(negedge clk); tx_reset = 0;
    chk("R8 tx_reset clears", {7'd0, tx_halted}, 8'd0);
    chk("R8 record kept", host_rd_data, 8'hA0);
    cyc(0, 0, 1);
    cyc(1, 4'b0010, 0);
    chk("R8 R2 underrun byte", host_rd_data, 8'h90);
    chk("R8 underrun halts", {7'd0, tx_halted}, 8'd1);
    cyc(0, 0, 1);
    tx_reset = 1; @(negedge clk); tx_reset = 0;
  endtask

  task automatic t_fail();
    fifo_overrun = 1; @(negedge clk); fifo_overrun = 0;
    chk("R9 fail set", {6'd0, tx_halted, adapter_fail}, 8'd3);
    chk("R9 no record", host_rd_data, 8'h00);
    repeat (2) @(negedge clk);
    chk("R9 holds", {6'd0, tx_halted, adapter_fail}, 8'd3);
    tx_reset = 1; @(negedge clk); tx_reset = 0;
    chk("R9 tx_reset clears", {6'd0, tx_halted, adapter_fail}, 8'd0);
    fifo_overrun = 1; @(negedge clk); fifo_overrun = 0;
    cyc(1, 4'b1000, 0);
    do_reset();
    chk("R10 reset empties", host_rd_data, 8'h00);
    chk("R10 reset clears flags", {6'd0, tx_halted, adapter_fail}, 8'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1; idle();
    @(negedge clk);
    t_reset();
    t_qualify();
    t_order();
    t_overflow();
    t_simul();
    t_empty_pop();
    t_halt();
    t_fail();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule